// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block merges a bank of 32 level-sensitive interrupt sources into four outgoing interrupt lines. Each group of eight adjacent sources shares one output. A source reaches its group output only while its enable bit is set. The outputs are meant to feed one input each of a primary interrupt controller. Software then reads a masked status word to find out which of the eight sources raised the line.

The enable bits are never written as a whole word. One register address sets the enable bits where the written data holds ones. A second address clears the enable bits where the written data holds ones. A third address returns the masked pending word. Bus reads return data one clock after the read request. Group outputs come from flip-flops, so they follow the inputs and the enables one clock later.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset, every enable bit is 0, every group output is low, and read data is 0 in any cycle that does not follow a read request.
- R2: A write to offset 0x0 sets enable bit n for every data bit n that is 1. Enable bits whose data bit is 0 keep their value.
- R3: A write to offset 0x4 clears enable bit n for every data bit n that is 1. Enable bits whose data bit is 0 keep their value. Writing all ones disables all 32 sources in a single access.
- R4: A read of offset 0x0 or offset 0x4 returns the 32-bit enable mask. Bit n of the mask is the enable of source n.
- R5: A read of offset 0xC returns the status word. Status bit n is raw source n ANDed with enable n.
- R6: Group output g (g = 0..3) is the OR of the masked status bits 8g through 8g+7. It is updated on the clock edge after the inputs or the enables change.
- R7: Sources are level-sensitive. A group output stays high for as long as an enabled source of its group is held high. It drops on the first clock edge after the last such source falls.
- R8: A read of offset 0x8 or of any unmapped offset returns 0. A write to any such offset leaves the enable mask unchanged.
- R9: Read data appears on the clock edge after the read request. A read issued in the same cycle as a write returns the values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Raw level interrupt sources |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after bus_rd |
| grp_irq_o | output | 4 | Combined interrupt line per group of eight |

## Verification
A read and a write can fall in the same cycle, because the address bus is shared. The bench provokes this by asserting both strobes at once, first on the enable-set offset and then on the enable-clear offset. The scoreboard expects the returned word to be the mask as it stood before that edge. A follow-up read must then show the new mask. Source edges that arrive in the same cycle as a change to the enables are judged the same way: the group output must equal the masked OR from the previous cycle.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int unsigned OFS_EN_SET = 0;
  localparam int unsigned OFS_EN_CLR = 4;
  localparam int unsigned OFS_RSVD   = 8;
  localparam int unsigned OFS_STATUS = 12;
endpackage

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] en_q
);
  // clear wins over set for any bit hit by both
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_mask) & ~clr_mask;
  end
endmodule

// File: rtl/irq_grp_or.sv
module irq_grp_or #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend,
  output logic         irq_q
);
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend;
  end
endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
  import irq_comb_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      en,
  input  logic [W-1:0]      status,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFS_EN_SET) || addr == ADDR_W'(OFS_EN_CLR)) sel = en;
    else if (addr == ADDR_W'(OFS_STATUS))                          sel = status;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
  import irq_comb_pkg::*;
#(
  parameter int unsigned GROUP_SIZE = 8,
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [GROUP_SIZE*NUM_GROUPS-1:0]    src_i,
  input  logic [ADDR_W-1:0]                   bus_addr,
  input  logic                                bus_wr,
  input  logic [GROUP_SIZE*NUM_GROUPS-1:0]    bus_wdata,
  input  logic                                bus_rd,
  output logic [GROUP_SIZE*NUM_GROUPS-1:0]    bus_rdata,
  output logic [NUM_GROUPS-1:0]               grp_irq_o
);
  localparam int unsigned W = GROUP_SIZE * NUM_GROUPS;

  logic [W-1:0] set_mask, clr_mask, en_q, status;

  assign set_mask = (bus_wr && bus_addr == ADDR_W'(OFS_EN_SET)) ? bus_wdata : '0;
  assign clr_mask = (bus_wr && bus_addr == ADDR_W'(OFS_EN_CLR)) ? bus_wdata : '0;
  assign status   = src_i & en_q;

  irq_en_bank #(.W(W)) u_en (
    .clk(clk), .rst(rst), .set_mask(set_mask), .clr_mask(clr_mask), .en_q(en_q)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    irq_grp_or #(.N(GROUP_SIZE)) u_or (
      .clk(clk), .rst(rst),
      .pend(status[g*GROUP_SIZE +: GROUP_SIZE]),
      .irq_q(grp_irq_o[g])
    );
  end

  irq_rd_port #(.W(W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd(bus_rd), .addr(bus_addr),
    .en(en_q), .status(status), .rdata(bus_rdata)
  );
endmodule

// File: rtl/irq_group_combiner_chk.sv
module irq_group_combiner_chk
  import irq_comb_pkg::*;
#(
  parameter int unsigned GROUP_SIZE = 8,
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned ADDR_W     = 4
) (
  input logic                             clk,
  input logic                             rst,
  input logic [GROUP_SIZE*NUM_GROUPS-1:0] src_i,
  input logic [ADDR_W-1:0]                bus_addr,
  input logic                             bus_wr,
  input logic [GROUP_SIZE*NUM_GROUPS-1:0] bus_wdata,
  input logic                             bus_rd,
  input logic [GROUP_SIZE*NUM_GROUPS-1:0] bus_rdata,
  input logic [NUM_GROUPS-1:0]            grp_irq_o,
  input logic [GROUP_SIZE*NUM_GROUPS-1:0] en
);
  logic is_set, is_clr, is_stat, is_mapped;
  assign is_set    = bus_addr == ADDR_W'(OFS_EN_SET);
  assign is_clr    = bus_addr == ADDR_W'(OFS_EN_CLR);
  assign is_stat   = bus_addr == ADDR_W'(OFS_STATUS);
  assign is_mapped = is_set || is_clr;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $fell(rst) |-> (grp_irq_o == '0 && en == '0));

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_set) |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));

  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && is_clr) |=> ((en & $past(bus_wdata)) == '0));

  assert_mask_read_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_mapped) |=> (bus_rdata == $past(en)));

  assert_status_read_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && is_stat) |=> (bus_rdata == $past(src_i & en)));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_group_or_R6: assert property (@(posedge clk) disable iff (rst)
      grp_irq_o[g] == |$past(src_i[g*GROUP_SIZE +: GROUP_SIZE] & en[g*GROUP_SIZE +: GROUP_SIZE]));
  end

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !is_mapped) |=> $stable(en));

  assert_unmapped_read_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !is_mapped && !is_stat) |=> (bus_rdata == '0));
endmodule

bind irq_group_combiner irq_group_combiner_chk #(
  .GROUP_SIZE(GROUP_SIZE), .NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)
) chk (
  .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .grp_irq_o(grp_irq_o), .en(en_q)
);

// File: tb/irq_group_combiner_test.sv
module irq_group_combiner_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_i = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [31:0] exp_en = '0;

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_combiner uut (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .grp_irq_o(grp_irq_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] grp_model(logic [31:0] s, logic [31:0] e);
    logic [3:0] r;
    for (int g = 0; g < 4; g++) r[g] = |(s[g*8 +: 8] & e[g*8 +: 8]);
    return r;
  endfunction

  function automatic logic [31:0] read_model(logic [3:0] a);
    if (a == 4'h0 || a == 4'h4) return exp_en;
    if (a == 4'hC) return src_i & exp_en;
    return '0;
  endfunction

  // monitor: pops one expected word for each read accepted at an edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd && !rst) begin
        exp_t e;
        #(CLK_PERIOD/4);
        if (sb.size() == 0) check("scoreboard underflow", 32'h1, 32'h0);
        else begin
          e = sb.pop_front();
          check(e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  // one access; rd and wr may be combined in the same cycle
  task automatic access(logic [3:0] a, logic wr, logic [31:0] d, logic rd, string tag);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = d; bus_rd = rd;
    if (rd) sb.push_back('{read_model(a), tag});
    @(posedge clk);
    if (wr && a == 4'h0) exp_en = exp_en | d;
    if (wr && a == 4'h4) exp_en = exp_en & ~d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic settle_grp(string tag);
    @(negedge clk);
    @(negedge clk);
    check(tag, {28'h0, grp_irq_o}, {28'h0, grp_model(src_i, exp_en)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 grp after reset", {28'h0, grp_irq_o}, 32'h0);
    check("R1 rdata idle", bus_rdata, 32'h0);
    src_i = 32'hFFFF_FFFF;
    settle_grp("R1 sources high but disabled");
    src_i = '0;
    access(4'h0, 0, '0, 1, "R1 mask zero after reset");
    // R2
    access(4'h0, 1, 32'h8100_0101, 0, "");
    access(4'h0, 0, '0, 1, "R2 set bits 0,8,24,31");
    access(4'h0, 1, 32'h0000_0002, 0, "");
    access(4'h4, 0, '0, 1, "R2 zero bits keep enable / R4 via clr offset");
    // R3
    access(4'h4, 1, 32'h0000_0001, 0, "");
    access(4'h0, 0, '0, 1, "R3 clear bit0 only");
    // R5
    src_i = 32'hFFFF_FFFF;
    access(4'hC, 0, '0, 1, "R5 status all raw high");
    src_i = 32'h0100_0003;
    access(4'hC, 0, '0, 1, "R5 status partial");
    // R6
    src_i = 32'h0000_0100; settle_grp("R6 group1 only");
    src_i = 32'h0000_0001; settle_grp("R6 masked source");
    src_i = 32'h8000_0000; settle_grp("R6 group3 top bit");
    src_i = 32'h8100_0102; settle_grp("R6 three groups");
    // R7: level hold, then registered drop
    src_i = 32'h0000_0100;
    settle_grp("R7 asserted");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 held while level high", {28'h0, grp_irq_o}, 32'h2);
    end
    src_i = '0;
    #1 check("R7 still high before edge", {28'h0, grp_irq_o}, 32'h2);
    @(negedge clk);
    check("R7 low after one edge", {28'h0, grp_irq_o}, 32'h0);
    // R8
    access(4'h8, 1, 32'hFFFF_FFFF, 0, "");
    access(4'h2, 1, 32'hFFFF_FFFF, 0, "");
    access(4'h0, 0, '0, 1, "R8 unmapped writes ignored");
    access(4'h8, 0, '0, 1, "R8 read reserved 0x8");
    src_i = 32'hFFFF_FFFF;
    access(4'h3, 0, '0, 1, "R8 read unmapped 0x3");
    // R9: read in same cycle as write
    access(4'h0, 1, 32'h00FF_0000, 1, "R9 set+read returns old mask");
    access(4'h0, 0, '0, 1, "R9 new mask after set");
    access(4'h4, 1, 32'h0000_0100, 1, "R9 clr+read returns old mask");
    access(4'hC, 0, '0, 1, "R9 status after clr");
    // enable change with sources already high
    settle_grp("R6 after enable change");
    // R3 all ones
    access(4'h4, 1, 32'hFFFF_FFFF, 0, "");
    access(4'h0, 0, '0, 1, "R3 all-ones clear");
    settle_grp("R3 all groups low");
    repeat (2) @(negedge clk);
    check("scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule